// File: doc/BRIEF.md
# Sector-Erase Flash Command Controller

This block is the control side of a byte-wide, single-supply NOR flash. A host talks to it over an asynchronous-style bus with active-low chip select, write strobe and read strobe, a 19-bit address and an 8-bit data path. All bus pins are sampled on the system clock. A write is the falling edge of the write strobe while the chip is selected. A read is the falling edge of the read strobe while the chip is selected and the write strobe is high. Each read updates the data output register at that clock edge, and the value holds until the next read.

Bus writes are decoded as command sequences. Each sequence starts with a two-cycle unlock prefix. The sequences start a timed byte program, a multi-sector erase or a whole-chip erase on a small on-chip array. The top three address bits select one of eight sectors. The low `OFFS_W` address bits select a byte inside the modelled sector, and the bits in between are ignored by the array, so addresses that differ only there reach the same byte. An erase can be suspended, so that other sectors can be read and programmed, and then resumed. A per-sector protect input blocks program and erase. While an operation is busy, reads return a status word in place of array data. Software polls the status word, or the ready pin, to detect completion. Pulse lengths are set by cycle-count parameters.

Top module: `flashCmdCtl`

## Requirements
- R1: After reset, ready is 1, the data output is 0x00, and every array byte reads 0xFF.
- R2: The write sequence AA@555, 55@2AA, A0@555, then data@target starts a program. Ready goes low, and after PROG_CYC cycles the target byte becomes its old value AND the data. Programming can only clear bits.
- R3: A read during a program returns a status word: bit 7 is the complement of bit 7 of the programmed data, bit 6 inverts on every such read, and all other bits are 0.
- R4: The sequence AA@555, 55@2AA, 80@555, AA@555, 55@2AA, then 30@sector opens an erase window of WIN_CYC cycles. Each further write of 30 in the window adds its sector and restarts the window. When the window expires, the selected sectors are first pre-programmed to 0x00 and then set to 0xFF. Other sectors keep their data.
- R5: Ending the erase sequence with 10@555 in place of 30@sector erases every unprotected sector at once, with no window.
- R6: A read during an erase or its window returns a status word: bit 7 is 0, bit 6 inverts on every such read, and bit 2 inverts only on reads of a selected sector and holds its value on reads of other sectors. All other bits are 0.
- R7: Writing B0 while an erase runs suspends it within the same cycle, and ready returns to 1. While suspended, reads of unselected sectors return array data. Reads of selected sectors return a status word with bit 7 = 1, bit 6 held, bit 2 inverting, and all other bits 0.
- R8: While an erase is suspended, the program sequence works on unselected sectors and is ignored on selected sectors (ready stays 1).
- R9: A single write of 30 while suspended resumes the erase (ready goes 0), and the erase then completes.
- R10: When a sector's bit of the protect input is set, program and erase requests for that sector leave its bytes unchanged. A program to a protected sector leaves ready at 1.
- R11: Unlock addresses are matched on address bits 10:0 only. A wrong data or address value anywhere in a sequence returns the decoder to read mode. F0 resets the decoder at any step. Neither of these changes the array.
- R12: During a program, and during an erase except for B0 (suspend) and 30 inside the window, bus writes are ignored and do not advance the decoder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip select, active low |
| weN | input | 1 | Write strobe, active low, falling edge is a write |
| oeN | input | 1 | Read strobe, active low, falling edge is a read |
| addr | input | 19 | Byte address, bits 18:16 select the sector |
| dataIn | input | 8 | Write data or command byte |
| protMask | input | 8 | Per-sector protect, bit n guards sector n |
| dataOut | output | 8 | Registered read data or status word |
| ready | output | 1 | 1 when no program or erase is running |

## Verification
The bench goes after the status bits. A design that inverts bit 2 on reads of unselected sectors, or that inverts bit 6 while suspended, fails the exact status-word checks. Suspend timing is probed by suspending in mid-erase, programming both an unselected and a selected sector, and then resuming. A design that pauses late, accepts the selected-sector program, or loses its place in the erase shows wrong bytes or a wrong ready level. Other checks cover: a window that does not restart on added sectors; a protected sector that is erased anyway; a program that sets bits instead of ANDing; and writes during busy that leak into the decoder and cause a later stray program. Each of these is caught by byte read-backs against the bench's own array model.

// File: rtl/flashCmdPkg.sv
package flashCmdPkg;
  localparam int ADDR_W   = 19;
  localparam int DATA_W   = 8;
  localparam int SECT_W   = 3;
  localparam int NUM_SECT = 1 << SECT_W;

  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int TOG2_BIT = 2;

  localparam logic [DATA_W-1:0] CMD_UNL_A = 8'hAA;
  localparam logic [DATA_W-1:0] CMD_UNL_B = 8'h55;
  localparam logic [DATA_W-1:0] CMD_PGM   = 8'hA0;
  localparam logic [DATA_W-1:0] CMD_ERS   = 8'h80;
  localparam logic [DATA_W-1:0] CMD_SECT  = 8'h30;
  localparam logic [DATA_W-1:0] CMD_CHIP  = 8'h10;
  localparam logic [DATA_W-1:0] CMD_SUSP  = 8'hB0;
  localparam logic [DATA_W-1:0] CMD_RST   = 8'hF0;
  localparam logic [10:0] UNL_ADDR_A = 11'h555;
  localparam logic [10:0] UNL_ADDR_B = 11'h2AA;

  typedef enum logic [1:0] {RD_ARRAY, RD_PGM, RD_ERS, RD_SUSP} rdMode_e;
  typedef enum logic [1:0] {OP_IDLE, OP_WIN, OP_PROG, OP_ERASE} op_e;
  typedef enum logic [1:0] {ST_PRE, ST_PULSE, ST_VER} ersStage_e;
  typedef enum logic [2:0] {C_READ, C_UNL1, C_UNL2, C_PGM, C_ERS1, C_ERS2, C_ERS3} cmd_e;

  typedef struct packed {
    logic                  memPgm;
    logic                  memErase;
    logic [ADDR_W-1:0]     memAddr;
    logic [DATA_W-1:0]     memData;
    logic                  rdStb;
    rdMode_e               rdMode;
    logic [NUM_SECT-1:0]   eraseSet;
    logic                  pgmD7;
  } ctlStrobes_t;

  function automatic logic [DATA_W-1:0] statusWord(logic poll, logic t1, logic t2);
    logic [DATA_W-1:0] w;
    w = '0;
    w[POLL_BIT] = poll;
    w[TOG_BIT]  = t1;
    w[TOG2_BIT] = t2;
    return w;
  endfunction
endpackage

// File: rtl/flashCtrl.sv
module flashCtrl
  import flashCmdPkg::*;
#(
  parameter int OFFS_W    = 3,
  parameter int PROG_CYC  = 20,
  parameter int WIN_CYC   = 40,
  parameter int ERASE_CYC = 30
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ceN,
  input  logic                weN,
  input  logic                oeN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [NUM_SECT-1:0] protMask,
  output ctlStrobes_t         ctl,
  output logic                ready
);
  localparam int IDX_W   = SECT_W + OFFS_W;
  localparam int CNT_MAX = (PROG_CYC > WIN_CYC) ? PROG_CYC : WIN_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int PLS_W   = $clog2(ERASE_CYC + 1);

  op_e                 op;
  ersStage_e           stage;
  cmd_e                cmd;
  logic                susp;
  logic [NUM_SECT-1:0] eraseSet;
  logic [CNT_W-1:0]    opCnt;
  logic [PLS_W-1:0]    pulseCnt;
  logic [IDX_W-1:0]    idx;
  logic [ADDR_W-1:0]   pgmAddr;
  logic [DATA_W-1:0]   pgmData;
  logic                weP, oeP;

  logic                wrStb, rdStb, isA, isB;
  logic [SECT_W-1:0]   wSect, idxSect;
  logic [ADDR_W-1:0]   idxAddr;
  logic                unusedMid;

  assign wrStb   = !ceN && !weN && weP;
  assign rdStb   = !ceN && !oeN && weN && oeP;
  assign wSect   = addr[ADDR_W-1 -: SECT_W];
  assign isA     = (addr[10:0] == UNL_ADDR_A);
  assign isB     = (addr[10:0] == UNL_ADDR_B);
  assign idxSect = idx[IDX_W-1 -: SECT_W];
  assign unusedMid = ^addr[ADDR_W-SECT_W-1:11];

  always_comb begin
    idxAddr = '0;
    idxAddr[ADDR_W-1 -: SECT_W] = idxSect;
    idxAddr[OFFS_W-1:0]         = idx[OFFS_W-1:0];
  end

  // strobes toward the datapath
  always_comb begin
    ctl.memPgm   = 1'b0;
    ctl.memErase = 1'b0;
    ctl.memAddr  = idxAddr;
    ctl.memData  = '0;
    if (op == OP_PROG) begin
      ctl.memPgm  = (opCnt == '0);
      ctl.memAddr = pgmAddr;
      ctl.memData = pgmData;
    end else if (op == OP_ERASE) begin
      ctl.memPgm   = (stage == ST_PRE) && eraseSet[idxSect];
      ctl.memErase = (stage == ST_VER) && eraseSet[idxSect];
    end
    ctl.rdStb    = rdStb;
    ctl.eraseSet = eraseSet;
    ctl.pgmD7    = pgmData[DATA_W-1];
    case (op)
      OP_PROG:         ctl.rdMode = RD_PGM;
      OP_WIN, OP_ERASE: ctl.rdMode = RD_ERS;
      default:         ctl.rdMode = susp ? RD_SUSP : RD_ARRAY;
    endcase
  end

  assign ready = (op == OP_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      op       <= OP_IDLE;
      stage    <= ST_PRE;
      cmd      <= C_READ;
      susp     <= 1'b0;
      eraseSet <= '0;
      opCnt    <= '0;
      pulseCnt <= '0;
      idx      <= '0;
      pgmAddr  <= '0;
      pgmData  <= '0;
      weP      <= 1'b1;
      oeP      <= 1'b1;
    end else begin
      weP <= weN;
      oeP <= oeN;
      case (op)
        OP_PROG: begin
          if (opCnt == '0) op <= OP_IDLE;
          else             opCnt <= opCnt - 1'b1;
        end
        OP_WIN: begin
          if (wrStb && dataIn == CMD_SECT) begin
            if (!protMask[wSect]) eraseSet[wSect] <= 1'b1;
            opCnt <= CNT_W'(WIN_CYC);
          end else if (opCnt == '0) begin
            if (eraseSet == '0) op <= OP_IDLE;
            else begin
              op    <= OP_ERASE;
              stage <= ST_PRE;
              idx   <= '0;
            end
          end else begin
            opCnt <= opCnt - 1'b1;
          end
        end
        OP_ERASE: begin
          if (wrStb && dataIn == CMD_SUSP) begin
            susp <= 1'b1;
            op   <= OP_IDLE;
          end else begin
            case (stage)
              ST_PRE: begin
                idx <= idx + 1'b1;
                if (&idx) begin
                  stage    <= ST_PULSE;
                  pulseCnt <= PLS_W'(ERASE_CYC);
                end
              end
              ST_PULSE: begin
                if (pulseCnt == '0) begin
                  stage <= ST_VER;
                  idx   <= '0;
                end else begin
                  pulseCnt <= pulseCnt - 1'b1;
                end
              end
              default: begin
                if (&idx) begin
                  op       <= OP_IDLE;
                  eraseSet <= '0;
                end else begin
                  idx <= idx + 1'b1;
                end
              end
            endcase
          end
        end
        default: begin
          if (wrStb) begin
            if (dataIn == CMD_RST) begin
              cmd <= C_READ;
            end else begin
              case (cmd)
                C_READ: begin
                  if (susp && dataIn == CMD_SECT) begin
                    susp <= 1'b0;
                    op   <= OP_ERASE;
                  end else if (isA && dataIn == CMD_UNL_A) begin
                    cmd <= C_UNL1;
                  end
                end
                C_UNL1: cmd <= (isB && dataIn == CMD_UNL_B) ? C_UNL2 : C_READ;
                C_UNL2: begin
                  if (isA && dataIn == CMD_PGM)              cmd <= C_PGM;
                  else if (isA && dataIn == CMD_ERS && !susp) cmd <= C_ERS1;
                  else                                        cmd <= C_READ;
                end
                C_PGM: begin
                  cmd <= C_READ;
                  if (!protMask[wSect] && !(susp && eraseSet[wSect])) begin
                    op      <= OP_PROG;
                    opCnt   <= CNT_W'(PROG_CYC);
                    pgmAddr <= addr;
                    pgmData <= dataIn;
                  end
                end
                C_ERS1: cmd <= (isA && dataIn == CMD_UNL_A) ? C_ERS2 : C_READ;
                C_ERS2: cmd <= (isB && dataIn == CMD_UNL_B) ? C_ERS3 : C_READ;
                C_ERS3: begin
                  cmd <= C_READ;
                  if (dataIn == CMD_SECT) begin
                    if (!protMask[wSect]) eraseSet[wSect] <= 1'b1;
                    op    <= OP_WIN;
                    opCnt <= CNT_W'(WIN_CYC);
                  end else if (isA && dataIn == CMD_CHIP && (~protMask != '0)) begin
                    eraseSet <= ~protMask;
                    op       <= OP_ERASE;
                    stage    <= ST_PRE;
                    idx      <= '0;
                  end
                end
                default: cmd <= C_READ;
              endcase
            end
          end
        end
      endcase
    end
  end

  // R7
  susp_halts_erase_chk: assert property (@(posedge clk) disable iff (!rstN)
    susp |-> (op != OP_ERASE && op != OP_WIN));

  // R10
  erase_skips_prot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (op == OP_ERASE) |-> ((eraseSet & protMask) == '0));

  // R12
  busy_only_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ready) |-> $past(wrStb));
endmodule

// File: rtl/flashData.sv
module flashData
  import flashCmdPkg::*;
#(
  parameter int OFFS_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_SECT-1:0] protMask,
  input  ctlStrobes_t         ctl,
  output logic [DATA_W-1:0]   dataOut
);
  localparam int IDX_W = SECT_W + OFFS_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [SECT_W-1:0] rSect, wSect;
  logic [IDX_W-1:0]  rIdx, wIdx;
  logic [DATA_W-1:0] oldByte;
  logic              rdSel, tog, tog2;
  logic              unusedMid;

  assign rSect   = addr[ADDR_W-1 -: SECT_W];
  assign wSect   = ctl.memAddr[ADDR_W-1 -: SECT_W];
  assign rIdx    = {rSect, addr[OFFS_W-1:0]};
  assign wIdx    = {wSect, ctl.memAddr[OFFS_W-1:0]};
  assign oldByte = mem[wIdx];
  assign rdSel   = ctl.eraseSet[rSect];
  assign unusedMid = ^{addr[ADDR_W-SECT_W-1:OFFS_W], ctl.memAddr[ADDR_W-SECT_W-1:OFFS_W]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      dataOut <= '0;
      tog     <= 1'b0;
      tog2    <= 1'b0;
    end else begin
      if (ctl.memPgm)        mem[wIdx] <= oldByte & ctl.memData;
      else if (ctl.memErase) mem[wIdx] <= '1;
      if (ctl.rdStb) begin
        case (ctl.rdMode)
          RD_PGM: begin
            tog     <= ~tog;
            dataOut <= statusWord(~ctl.pgmD7, ~tog, 1'b0);
          end
          RD_ERS: begin
            tog     <= ~tog;
            tog2    <= tog2 ^ rdSel;
            dataOut <= statusWord(1'b0, ~tog, tog2 ^ rdSel);
          end
          RD_SUSP: begin
            if (rdSel) begin
              tog2    <= ~tog2;
              dataOut <= statusWord(1'b1, tog, ~tog2);
            end else begin
              dataOut <= mem[rIdx];
            end
          end
          default: dataOut <= mem[rIdx];
        endcase
      end
    end
  end

  // R3
  pgm_poll_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdStb && ctl.rdMode == RD_PGM) |=> (dataOut[POLL_BIT] == ~$past(ctl.pgmD7)));

  // R2
  pgm_clear_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.memPgm |=> ((mem[$past(wIdx)] & ~$past(oldByte)) == '0));

  // R10
  no_prot_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.memPgm || ctl.memErase) |-> !protMask[wSect]);
endmodule

// File: rtl/flashCmdCtl.sv
module flashCmdCtl
  import flashCmdPkg::*;
#(
  parameter int OFFS_W    = 3,
  parameter int PROG_CYC  = 20,
  parameter int WIN_CYC   = 40,
  parameter int ERASE_CYC = 30
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        weN,
  input  logic        oeN,
  input  logic [18:0] addr,
  input  logic [7:0]  dataIn,
  input  logic [7:0]  protMask,
  output logic [7:0]  dataOut,
  output logic        ready
);
  ctlStrobes_t ctl;

  flashCtrl #(
    .OFFS_W(OFFS_W), .PROG_CYC(PROG_CYC), .WIN_CYC(WIN_CYC), .ERASE_CYC(ERASE_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .protMask(protMask),
    .ctl(ctl), .ready(ready)
  );

  flashData #(.OFFS_W(OFFS_W)) uData (
    .clk(clk), .rstN(rstN), .addr(addr), .protMask(protMask),
    .ctl(ctl), .dataOut(dataOut)
  );
endmodule

// File: tb/flashCmdCtl_test.sv
module flashCmdCtl_test;
  localparam int OFFS_W = 3, PROG_CYC = 20, WIN_CYC = 40, ERASE_CYC = 30;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, ceN, weN, oeN, ready;
  logic [18:0] addr;
  logic [7:0] dataIn, protMask, dataOut;

  flashCmdCtl #(.OFFS_W(OFFS_W), .PROG_CYC(PROG_CYC), .WIN_CYC(WIN_CYC), .ERASE_CYC(ERASE_CYC)) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .dataIn(dataIn), .protMask(protMask), .dataOut(dataOut), .ready(ready));

  int nChk = 0, nErr = 0;
  logic [7:0] expMem [64];
  logic expTog = 1'b0, expTog2 = 1'b0, suspMode = 1'b0;
  logic [7:0] ersSel = 8'h00;
  logic [7:0] rd;
  bit finished = 0;

  function automatic logic [18:0] at(int s, int o);
    return {3'(s), 13'h0, 3'(o)};
  endfunction

  function automatic int ix(logic [18:0] a);
    return int'({a[18:16], a[2:0]});
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic busWrite(logic [18:0] a, logic [7:0] d);
    @(negedge clk); ceN = 0; weN = 0; addr = a; dataIn = d;
    @(negedge clk); weN = 1; ceN = 1;
  endtask

  task automatic busRead(logic [18:0] a, output logic [7:0] d);
    @(negedge clk); ceN = 0; oeN = 0; addr = a;
    @(negedge clk); d = dataOut; oeN = 1; ceN = 1;
  endtask

  task automatic waitReady(string tag);
    int n = 0;
    while (!ready && n < 3000) begin @(negedge clk); n++; end
    chk(tag, {7'b0, ready}, 8'h01);
  endtask

  function automatic logic [7:0] pgmStat(logic [7:0] d);
    expTog = ~expTog;
    return {~d[7], expTog, 6'b0};
  endfunction

  function automatic logic [7:0] ersStat(logic sel);
    expTog = ~expTog;
    if (sel) expTog2 = ~expTog2;
    return {1'b0, expTog, 3'b0, expTog2, 2'b0};
  endfunction

  function automatic logic [7:0] suspStat();
    expTog2 = ~expTog2;
    return {1'b1, expTog, 3'b0, expTog2, 2'b0};
  endfunction

  task automatic unlock();
    busWrite(19'h00555, 8'hAA);
    busWrite(19'h002AA, 8'h55);
  endtask

  task automatic cmdProgram(logic [18:0] a, logic [7:0] d);
    unlock();
    busWrite(19'h00555, 8'hA0);
    busWrite(a, d);
    if (!protMask[a[18:16]] && !(suspMode && ersSel[a[18:16]]))
      expMem[ix(a)] = expMem[ix(a)] & d;
  endtask

  task automatic eraseHead();
    unlock();
    busWrite(19'h00555, 8'h80);
    unlock();
  endtask

  task automatic modelErase();
    for (int i = 0; i < 64; i++) if (ersSel[i >> 3]) expMem[i] = 8'hFF;
    ersSel = 8'h00;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) expMem[i] = 8'hFF;
    rstN = 0; ceN = 1; weN = 1; oeN = 1; addr = '0; dataIn = '0; protMask = 8'h00;
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1 reset state
    chk("R1 ready", {7'b0, ready}, 8'h01);
    chk("R1 dataOut", dataOut, 8'h00);
    busRead(at(0, 0), rd); chk("R1 erased s0", rd, 8'hFF);
    busRead(at(7, 7), rd); chk("R1 erased s7", rd, 8'hFF);

    // R2 / R3 program and polling status
    cmdProgram(at(1, 2), 8'hA5);
    busRead(at(1, 2), rd); chk("R3 poll 1", rd, pgmStat(8'hA5));
    busRead(at(3, 0), rd); chk("R3 poll 2", rd, pgmStat(8'hA5));
    chk("R2 busy", {7'b0, ready}, 8'h00);
    waitReady("R2 done");
    busRead(at(1, 2), rd); chk("R2 data", rd, expMem[ix(at(1, 2))]);
    cmdProgram(at(1, 2), 8'h3C);
    busRead(at(1, 2), rd); chk("R3 poll d7=0", rd, pgmStat(8'h3C));
    waitReady("R2 done 2");
    busRead(at(1, 2), rd); chk("R2 and-only", rd, 8'h24);

    // R12 writes during program ignored
    cmdProgram(at(1, 4), 8'h0F);
    unlock(); busWrite(19'h00555, 8'hA0); busWrite(at(1, 6), 8'h00);
    waitReady("R12 done");
    busRead(at(1, 6), rd); chk("R12 ignored", rd, 8'hFF);
    busRead(at(1, 4), rd); chk("R12 target", rd, 8'h0F);

    // R11 malformed sequence, reset command, address match on low bits
    unlock(); busWrite(19'h00555, 8'h77); busWrite(at(3, 1), 8'h00);
    busRead(at(3, 1), rd); chk("R11 bad cmd", rd, 8'hFF);
    unlock(); busWrite(19'h00555, 8'hA0); busWrite(19'h00000, 8'hF0); busWrite(at(3, 1), 8'h00);
    busRead(at(3, 1), rd); chk("R11 reset", rd, 8'hFF);
    busWrite(19'h4_0555, 8'hAA); busWrite(19'h2_F2AA, 8'h55); busWrite(19'h7_8555, 8'hA0);
    busWrite(at(3, 1), 8'h5A); expMem[ix(at(3, 1))] = 8'h5A;
    waitReady("R11 alias done");
    busRead(at(3, 1), rd); chk("R11 low-bit match", rd, 8'h5A);

    // R10 protection
    cmdProgram(at(5, 3), 8'h55); waitReady("R10 prep");
    protMask = 8'h20;
    cmdProgram(at(5, 4), 8'h00);
    chk("R10 prog ready", {7'b0, ready}, 8'h01);
    busRead(at(5, 4), rd); chk("R10 prog blocked", rd, 8'hFF);

    // R4 / R6 multi-sector erase with window
    cmdProgram(at(0, 1), 8'h11); waitReady("R4 prep a");
    cmdProgram(at(2, 0), 8'h22); waitReady("R4 prep b");
    cmdProgram(at(4, 7), 8'h44); waitReady("R4 prep c");
    eraseHead(); busWrite(at(0, 5), 8'h30);
    busWrite(at(2, 0), 8'h30);
    busWrite(at(5, 0), 8'h30);
    ersSel = 8'h05;
    chk("R4 busy", {7'b0, ready}, 8'h00);
    busRead(at(0, 1), rd); chk("R6 sel s0", rd, ersStat(1'b1));
    busRead(at(4, 7), rd); chk("R6 unsel s4", rd, ersStat(1'b0));
    busRead(at(2, 0), rd); chk("R6 sel s2", rd, ersStat(1'b1));
    waitReady("R4 done");
    modelErase();
    busRead(at(0, 1), rd); chk("R4 s0 erased", rd, 8'hFF);
    busRead(at(2, 0), rd); chk("R4 s2 erased", rd, 8'hFF);
    busRead(at(4, 7), rd); chk("R4 s4 kept", rd, 8'h44);
    busRead(at(5, 3), rd); chk("R10 erase blocked", rd, 8'h55);
    busRead(at(1, 4), rd); chk("R4 s1 kept", rd, 8'h0F);

    // R7 / R8 / R9 suspend, program, resume
    protMask = 8'h00;
    cmdProgram(at(6, 1), 8'h81); waitReady("R7 prep a");
    cmdProgram(at(2, 5), 8'h3C); waitReady("R7 prep b");
    eraseHead(); busWrite(at(2, 0), 8'h30); ersSel = 8'h04;
    repeat (WIN_CYC + 6) @(negedge clk);
    chk("R4 erase running", {7'b0, ready}, 8'h00);
    busWrite(19'h00000, 8'hB0); suspMode = 1;
    chk("R7 ready", {7'b0, ready}, 8'h01);
    busRead(at(6, 1), rd); chk("R7 unsel data", rd, 8'h81);
    busRead(at(2, 5), rd); chk("R7 sel stat 1", rd, suspStat());
    busRead(at(2, 6), rd); chk("R7 sel stat 2", rd, suspStat());
    cmdProgram(at(4, 2), 8'h5A);
    busRead(at(4, 2), rd); chk("R8 pgm stat", rd, pgmStat(8'h5A));
    waitReady("R8 done");
    busRead(at(4, 2), rd); chk("R8 unsel program", rd, 8'h5A);
    cmdProgram(at(2, 3), 8'h00);
    chk("R8 sel program refused", {7'b0, ready}, 8'h01);
    busWrite(19'h00000, 8'h30); suspMode = 0;
    chk("R9 resumed", {7'b0, ready}, 8'h00);
    busRead(at(2, 1), rd); chk("R9 stat", rd, ersStat(1'b1));
    waitReady("R9 done");
    modelErase();
    busRead(at(2, 5), rd); chk("R9 s2 erased", rd, 8'hFF);
    busRead(at(2, 3), rd); chk("R9 s2 byte3", rd, 8'hFF);
    busRead(at(6, 1), rd); chk("R9 s6 kept", rd, 8'h81);

    // R5 chip erase with one protected sector
    cmdProgram(at(7, 6), 8'h77); waitReady("R5 prep");
    protMask = 8'h80;
    eraseHead(); busWrite(19'h00555, 8'h10); ersSel = 8'h7F;
    busRead(at(7, 6), rd); chk("R6 unsel steady", rd, ersStat(1'b0));
    busRead(at(3, 1), rd); chk("R6 sel chip", rd, ersStat(1'b1));
    waitReady("R5 done");
    modelErase();
    busRead(at(7, 6), rd); chk("R5 protected kept", rd, 8'h77);
    busRead(at(4, 2), rd); chk("R5 s4 erased", rd, 8'hFF);

    // random programs through aliased addresses (R2, R10)
    protMask = 8'h10;
    for (int it = 0; it < 24; it++) begin
      int s = $urandom_range(7);
      int o = $urandom_range(7);
      logic [12:0] j = 13'($urandom);
      logic [7:0] d = 8'($urandom);
      cmdProgram({3'(s), j, 3'(o)}, d);
      waitReady("R2 random done");
      busRead(at(s, o), rd); chk("R2 random", rd, expMem[s * 8 + o]);
    end
    for (int i = 0; i < 64; i++) begin
      busRead(at(i >> 3, i & 7), rd); chk("R2 sweep", rd, expMem[i]);
    end
    finishRun();
  end
endmodule